// File: doc/BRIEF.md
# Supply Supervisor Reset Sequencer

This block is the digital half of a power-supply supervisor. An external comparator reports two asynchronous flags: one says the supply sits below the trip threshold, the other says the dip has gone deep below it. The block synchronizes both flags and rejects brief supply glitches. A shallow dip is tolerated for a longer window than a deep one. Once a dip outlasts its window, the block drives a system reset, and it keeps that reset asserted for a fixed timeout after the supply has come back.

All durations are parameters counted in clock cycles. At a 125 MHz clock the defaults give a shallow-dip window of 4 µs and a deep-dip window of 0.8 µs. They also give a recovery timeout of 240 ms, which lies inside the 140 ms to 460 ms window the supervisor must respect. A build-time parameter picks whether the push-pull reset output is active-low or active-high. On a clock-domain reset the output comes up asserted. The recovery timeout does not start until the synchronized supply flag reads good.

Top module: `supv_reset_seq`

## Requirements
- R1: The reset output is asserted while `rst_n` is low and after it is released. It stays asserted for as long as `supplyLowRaw` is held high.
- R2: When `supplyLowRaw` drops to 0 while reset is asserted, the output releases exactly HOLD_CYC+3 clock edges later. Two of those edges are synchronizer latency and one is the state change. This assumes no dip occurs in the meantime.
- R3: While released, a shallow dip in which `supplyLowRaw` is high for fewer than SHALLOW_CYC consecutive clock edges, with `supplyDeepRaw` low, leaves the output released.
- R4: While released, a shallow dip that holds `supplyLowRaw` high asserts reset exactly SHALLOW_CYC+2 clock edges after the dip begins.
- R5: When `supplyDeepRaw` is high together with `supplyLowRaw`, the qualifying window shrinks to DEEP_CYC edges. DEEP_CYC-1 edges are ignored, and a sustained deep dip asserts reset DEEP_CYC+2 edges after it begins.
- R6: `supplyDeepRaw` high while `supplyLowRaw` is low has no effect on the output.
- R7: A dip that qualifies during the recovery timeout keeps reset asserted and restarts the timeout from zero. Release then comes HOLD_CYC+3 edges after the supply next reads good.
- R8: A dip shorter than the window during the recovery timeout pauses the timeout without restarting it. Release is delayed by exactly the number of edges on which the synchronized flag read low-supply.
- R9: With ACTIVE_LOW=1 the output is low while reset is active. With ACTIVE_LOW=0 it is high while reset is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low clock-domain reset |
| supplyLowRaw | input | 1 | Comparator flag, high when the supply is below the trip threshold (asynchronous) |
| supplyDeepRaw | input | 1 | Comparator flag, high when the dip is deep below the threshold (asynchronous) |
| rstOut | output | 1 | Push-pull system reset, polarity set by ACTIVE_LOW |

## Verification
The embedded assertions check four rules on every cycle. A qualified dip always forces reset on the next edge. Reset only rises after a qualified dip. Release only follows a completed timeout on a good supply sample. A low-supply sample never lets an asserted reset drop. Exact latencies can only be shown by the bench scenarios: the SHALLOW_CYC+2 and DEEP_CYC+2 assertion delays, and the one-edge boundary between an ignored dip and a qualified one. The same holds for the HOLD_CYC+3 release, for the difference between a timeout that pauses and one that restarts, and for the output polarity of the two build variants.

// File: rtl/supv_pkg.sv
`timescale 1ns/1ps
package supv_pkg;

  typedef enum logic [1:0] {
    ST_LOW  = 2'd0,   // reset asserted, supply seen below threshold
    ST_HOLD = 2'd1,   // reset asserted, recovery timeout running
    ST_RUN  = 2'd2    // reset released
  } supvState_e;

  typedef struct packed {
    logic holdClr;    // restart the recovery timeout from zero
    logic holdRun;    // advance the recovery timeout this cycle
  } holdStrobe_t;

endpackage

// File: rtl/supv_sync.sv
`timescale 1ns/1ps
module supv_sync #(
  parameter int          WIDTH     = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);

  for (genvar g = 0; g < WIDTH; g++) begin : gBit
    logic stage1;
    logic stage2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1 <= RESET_VAL[g];
        stage2 <= RESET_VAL[g];
      end else begin
        stage1 <= dIn[g];
        stage2 <= stage1;
      end
    end
    assign dOut[g] = stage2;
  end

endmodule

// File: rtl/supv_datapath.sv
`timescale 1ns/1ps
module supv_datapath
  import supv_pkg::*;
#(
  parameter int SHALLOW_CYC = 500,
  parameter int DEEP_CYC    = 100,
  parameter int HOLD_CYC    = 30000000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        belowS,
  input  logic        deepS,
  input  holdStrobe_t strobe,
  output logic        dipQual,
  output logic        holdDone
);

  localparam int FW = $clog2(SHALLOW_CYC + 1);
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam logic [FW-1:0] SHALLOW_LAST = FW'(SHALLOW_CYC - 1);
  localparam logic [FW-1:0] DEEP_LAST    = FW'(DEEP_CYC - 1);
  localparam logic [HW-1:0] HOLD_LAST    = HW'(HOLD_CYC - 1);

  logic [FW-1:0] filtCnt;
  logic [FW-1:0] dipLimit;
  logic [HW-1:0] holdCnt;

  // consecutive low-supply samples seen before this cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filtCnt <= '0;
    end else if (!belowS) begin
      filtCnt <= '0;
    end else if (filtCnt < SHALLOW_LAST) begin
      filtCnt <= filtCnt + 1'b1;
    end
  end

  // a deep dip is judged against the shorter window
  assign dipLimit = deepS ? DEEP_LAST : SHALLOW_LAST;
  assign dipQual  = belowS && (filtCnt >= dipLimit);

  // recovery timeout, saturating at its last value
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      holdCnt <= '0;
    end else if (strobe.holdClr) begin
      holdCnt <= '0;
    end else if (strobe.holdRun && (holdCnt != HOLD_LAST)) begin
      holdCnt <= holdCnt + 1'b1;
    end
  end

  assign holdDone = (holdCnt == HOLD_LAST);

  AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    holdCnt <= HOLD_LAST); // R2

endmodule

// File: rtl/supv_ctrl.sv
`timescale 1ns/1ps
module supv_ctrl
  import supv_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        belowS,
  input  logic        dipQual,
  input  logic        holdDone,
  output holdStrobe_t strobe,
  output logic        rstActive
);

  supvState_e state;
  supvState_e stateNxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_LOW;
    else        state <= stateNxt;
  end

  always_comb begin
    stateNxt       = state;
    strobe.holdClr = 1'b0;
    strobe.holdRun = 1'b0;
    unique case (state)
      ST_LOW: begin
        strobe.holdClr = 1'b1;
        if (!belowS) stateNxt = ST_HOLD;
      end
      ST_HOLD: begin
        strobe.holdRun = !belowS;
        if (dipQual)                stateNxt = ST_LOW;
        else if (!belowS && holdDone) stateNxt = ST_RUN;
      end
      ST_RUN: begin
        if (dipQual) stateNxt = ST_LOW;
      end
      default: stateNxt = ST_LOW;
    endcase
  end

  assign rstActive = (state != ST_RUN);

  AST_QUAL_FORCES_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    dipQual |=> rstActive); // R4

  AST_ASSERT_NEEDS_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rstActive) |-> $past(dipQual)); // R3

  AST_RELEASE_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rstActive) |-> ($past(holdDone) && !$past(belowS))); // R2

endmodule

// File: rtl/supv_reset_seq.sv
`timescale 1ns/1ps
module supv_reset_seq
  import supv_pkg::*;
#(
  parameter int SHALLOW_CYC = 500,
  parameter int DEEP_CYC    = 100,
  parameter int HOLD_CYC    = 30000000,
  parameter bit ACTIVE_LOW  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supplyLowRaw,
  input  logic supplyDeepRaw,
  output logic rstOut
);

  logic [1:0]  syncOut;
  logic        belowS;
  logic        deepS;
  logic        dipQual;
  logic        holdDone;
  logic        rstActive;
  holdStrobe_t strobe;

  // both flags start out reading "below" so reset cannot drop early
  supv_sync #(.WIDTH(2), .RESET_VAL(2'b11)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .dIn   ({supplyDeepRaw, supplyLowRaw}),
    .dOut  (syncOut)
  );

  assign belowS = syncOut[0];
  assign deepS  = syncOut[1];

  supv_datapath #(
    .SHALLOW_CYC (SHALLOW_CYC),
    .DEEP_CYC    (DEEP_CYC),
    .HOLD_CYC    (HOLD_CYC)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .belowS   (belowS),
    .deepS    (deepS),
    .strobe   (strobe),
    .dipQual  (dipQual),
    .holdDone (holdDone)
  );

  supv_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .belowS    (belowS),
    .dipQual   (dipQual),
    .holdDone  (holdDone),
    .strobe    (strobe),
    .rstActive (rstActive)
  );

  if (ACTIVE_LOW) begin : gActLow
    assign rstOut = ~rstActive;
  end else begin : gActHigh
    assign rstOut = rstActive;
  end

  AST_BELOW_KEEPS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (rstActive && belowS) |=> rstActive); // R1

endmodule

// File: tb/supv_reset_seq_bench.sv
`timescale 1ns/1ps
module supv_reset_seq_bench;

  localparam int SH   = 8;
  localparam int DP   = 3;
  localparam int HOLD = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lowRaw = 1'b1;
  logic deepRaw = 1'b0;
  logic rstLo;
  logic rstHi;
  int   nCheck = 0;
  int   nFail  = 0;
  int   polBad = 0;
  bit   done   = 1'b0;

  always #4 clk = ~clk;

  supv_reset_seq #(.SHALLOW_CYC(SH), .DEEP_CYC(DP), .HOLD_CYC(HOLD), .ACTIVE_LOW(1'b1)) u_supv_reset_seq (
    .clk(clk), .rst_n(rst_n), .supplyLowRaw(lowRaw), .supplyDeepRaw(deepRaw), .rstOut(rstLo));

  supv_reset_seq #(.SHALLOW_CYC(SH), .DEEP_CYC(DP), .HOLD_CYC(HOLD), .ACTIVE_LOW(1'b0)) u_supv_reset_seq_hi (
    .clk(clk), .rst_n(rst_n), .supplyLowRaw(lowRaw), .supplyDeepRaw(deepRaw), .rstOut(rstHi));

  wire active = ~rstLo;

  always @(negedge clk) if (rstHi === rstLo) polBad++;

  task automatic check(input string req, input bit ok, input int act, input int exp);
    nCheck++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // counts negedges until reset releases; -1 if it never does
  task automatic waitRelease(input int maxN, output int n);
    n = -1;
    for (int i = 1; i <= maxN; i++) begin
      @(negedge clk);
      if (!active) begin n = i; break; end
    end
  endtask

  task automatic waitAssert(input int maxN, output int n);
    n = -1;
    for (int i = 1; i <= maxN; i++) begin
      @(negedge clk);
      if (active) begin n = i; break; end
    end
  endtask

  task automatic tReset();
    int seen = 0;
    lowRaw = 1'b1; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 asserted in reset", active, active, 1);
    rst_n = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!active) seen++;
    end
    check("R1 held while supply low", seen == 0, seen, 0);
  endtask

  task automatic tPowerUp();
    int n;
    lowRaw = 1'b0;
    waitRelease(HOLD + 10, n);
    check("R2 release latency", n == HOLD + 3, n, HOLD + 3);
  endtask

  task automatic tShallowIgnore();
    int n;
    lowRaw = 1'b1;
    repeat (SH - 1) @(negedge clk);
    lowRaw = 1'b0;
    waitAssert(SH + 10, n);
    check("R3 short shallow dip ignored", n == -1, n, -1);
  endtask

  task automatic tShallowTrip();
    int n;
    int seen = 0;
    lowRaw = 1'b1;
    waitAssert(SH + 10, n);
    check("R4 shallow trip latency", n == SH + 2, n, SH + 2);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (!active) seen++;
    end
    check("R1 stays asserted while low", seen == 0, seen, 0);
    lowRaw = 1'b0;
    waitRelease(HOLD + 10, n);
    check("R2 release after dip", n == HOLD + 3, n, HOLD + 3);
  endtask

  task automatic tDeep();
    int n;
    lowRaw = 1'b1; deepRaw = 1'b1;
    repeat (DP - 1) @(negedge clk);
    lowRaw = 1'b0; deepRaw = 1'b0;
    waitAssert(SH + 10, n);
    check("R5 short deep dip ignored", n == -1, n, -1);
    lowRaw = 1'b1; deepRaw = 1'b1;
    waitAssert(SH + 10, n);
    check("R5 deep trip latency", n == DP + 2, n, DP + 2);
    lowRaw = 1'b0; deepRaw = 1'b0;
    waitRelease(HOLD + 10, n);
    check("R2 release after deep dip", n == HOLD + 3, n, HOLD + 3);
  endtask

  task automatic tDeepAlone();
    int n;
    deepRaw = 1'b1;
    waitAssert(3 * SH, n);
    check("R6 deep flag alone ignored", n == -1, n, -1);
    deepRaw = 1'b0;
    waitAssert(5, n);
    check("R6 output still released", n == -1, n, -1);
  endtask

  task automatic tRetrigger();
    int n;
    lowRaw = 1'b1;
    waitAssert(SH + 10, n);
    lowRaw = 1'b0;
    repeat (6) @(negedge clk);
    check("R7 in timeout", active, active, 1);
    lowRaw = 1'b1;
    repeat (SH) @(negedge clk);
    lowRaw = 1'b0;
    waitRelease(HOLD + 10, n);
    check("R7 timeout restarted", n == HOLD + 3, n, HOLD + 3);
  endtask

  task automatic tPause();
    int n;
    int early = 0;
    lowRaw = 1'b1;
    waitAssert(SH + 10, n);
    lowRaw = 1'b0;
    for (int i = 0; i < 5; i++) begin @(negedge clk); if (!active) early++; end
    lowRaw = 1'b1;
    for (int i = 0; i < 3; i++) begin @(negedge clk); if (!active) early++; end
    lowRaw = 1'b0;
    waitRelease(HOLD + 20, n);
    check("R8 no early release", early == 0, early, 0);
    check("R8 paused timeout", n + 8 == HOLD + 6, n + 8, HOLD + 6);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      nCheck++; nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCheck, nFail);
      $finish;
    end
  end

  initial begin
    tReset();
    tPowerUp();
    tShallowIgnore();
    tShallowTrip();
    tDeep();
    tDeepAlone();
    tRetrigger();
    tPause();
    check("R9 polarity of both variants", polBad == 0, polBad, 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCheck, nFail);
    $finish;
  end

endmodule